// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a register datapath that runs one register-to-register operation every clock cycle. It holds seven general-purpose registers, G1 to G7. A 14-bit control word arrives on an input port. It picks a source for each of two operand buses, an ALU function, and a destination register. Either operand bus may take an external input word in place of a register. The ALU result is written back to the chosen register, if any, at the clock edge that ends the cycle.

The same result is registered onto the external output port in every cycle, whether or not a register is written. An outside sequencer reads a register by issuing a transfer of that register with no destination. It injects data by transferring the external input into a register. The data width is a parameter.

Top module: `cw_datapath`

## Requirements
- R1: A synchronous active-high reset clears all seven registers and `data_out` to zero.
- R2: The control word is laid out as bits [13:11] A-source, [10:8] B-source, [7:5] destination and [4:0] ALU code. A source or destination code of 1 to 7 selects register G1 to G7 respectively.
- R3: An A-source or B-source code of 000 places `ext_in` on that operand bus.
- R4: A destination code of 000 leaves every register unchanged.
- R5: A nonzero destination code writes the ALU result into exactly the one register it selects, at the clock edge that ends the cycle.
- R6: The arithmetic codes are 00001 A+1, 00010 A+B, 00101 A−B and 00110 A−1. All of them wrap modulo 2^DATA_W.
- R7: The bitwise codes are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A. Code 00000 passes A unchanged.
- R8: Code 10000 shifts A right by one bit and code 11000 shifts A left by one bit. Both shifts fill the vacated bit with zero.
- R9: Any ALU code not listed in R6 to R8 behaves as a pass of A.
- R10: `data_out` shows the ALU result of the control word applied in the previous cycle, whatever the destination code.
- R11: When the destination is also a source, the ALU uses the register's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 14 | Control word for this cycle |
| ext_in | input | DATA_W | External operand word |
| data_out | output | DATA_W | Registered ALU result |

## Verification
The register contents never reach a port directly. The hardest thing to show is that a cycle with destination 000, or a write aimed at one register, leaves all other registers untouched. The bench keeps a model of all seven registers. After each write it follows up with a no-destination pass of every register to `data_out`, so a stray load appears as a read-back mismatch. Corner values such as all-ones increment, zero decrement and the shift of the end bits come from external-input operands. Self-referencing operations such as G3 ← G3 + G3 are issued to test the read-before-write ordering.

// File: rtl/cw_dp_pkg.sv
package cw_dp_pkg;
  localparam int SEL_W  = 3;
  localparam int OP_W   = 5;
  localparam int NREG   = (1 << SEL_W) - 1;
  localparam int CW_W   = 3 * SEL_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [OP_W-1:0]  op;
  } ctrl_t;
endpackage

// File: rtl/cw_reg_bank.sv
module cw_reg_bank
  import cw_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              ld_en,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  reg_q
);
  // one flop row per register; index i holds register G(i+1)
  for (genvar i = 0; i < NREG; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        reg_q[i] <= '0;
      else if (ld_en[i])
        reg_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/cw_src_mux.sv
module cw_src_mux
  import cw_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [DATA_W-1:0]            ext_in,
  input  logic [NREG-1:0][DATA_W-1:0]  reg_q,
  output logic [DATA_W-1:0]            bus
);
  // code zero selects the external word, otherwise a register
  always_comb begin
    bus = ext_in;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SEL_W'(i + 1))
        bus = reg_q[i];
    end
  end
endmodule

// File: rtl/cw_dest_decode.sv
module cw_dest_decode
  import cw_dp_pkg::*;
(
  input  logic [SEL_W-1:0] dst,
  output logic [NREG-1:0]  ld_en
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign ld_en[i] = (dst == SEL_W'(i + 1));
  end
endmodule

// File: rtl/cw_alu.sv
module cw_alu
  import cw_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op)
      OP_INC:  y = a + ONE;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_DEC:  y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_SHR:  y = {1'b0, a[DATA_W-1:1]};
      OP_SHL:  y = {a[DATA_W-2:0], 1'b0};
      default: y = a; // pass, also for every unlisted code
    endcase
  end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] data_out
);
  ctrl_t                        cw;
  logic [NREG-1:0][DATA_W-1:0]  reg_q;
  logic [NREG-1:0]              ld_en;
  logic [DATA_W-1:0]            bus_a;
  logic [DATA_W-1:0]            bus_b;
  logic [DATA_W-1:0]            alu_y;

  assign cw = ctrl_t'(ctrl_word);

  cw_src_mux #(.DATA_W(DATA_W)) u_mux_a (
    .sel(cw.src_a), .ext_in(ext_in), .reg_q(reg_q), .bus(bus_a));

  cw_src_mux #(.DATA_W(DATA_W)) u_mux_b (
    .sel(cw.src_b), .ext_in(ext_in), .reg_q(reg_q), .bus(bus_b));

  cw_alu #(.DATA_W(DATA_W)) u_alu (
    .op(cw.op), .a(bus_a), .b(bus_b), .y(alu_y));

  cw_dest_decode u_dec (.dst(cw.dst), .ld_en(ld_en));

  cw_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .ld_en(ld_en), .wr_data(alu_y), .reg_q(reg_q));

  always_ff @(posedge clk) begin
    if (rst)
      data_out <= '0;
    else
      data_out <= alu_y;
  end
endmodule

// File: rtl/cw_datapath_chk.sv
module cw_datapath_chk
  import cw_dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CW_W-1:0]              ctrl_word,
  input  logic [DATA_W-1:0]            ext_in,
  input  logic [DATA_W-1:0]            data_out,
  input  logic [NREG-1:0]              ld_en,
  input  logic [NREG-1:0][DATA_W-1:0]  reg_q
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  wire [SEL_W-1:0] f_a   = ctrl_word[13:11];
  wire [SEL_W-1:0] f_b   = ctrl_word[10:8];
  wire [SEL_W-1:0] f_d   = ctrl_word[7:5];
  wire [OP_W-1:0]  f_op  = ctrl_word[4:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    started && $past(rst) |-> (data_out == '0) && (reg_q == '0));

  // R4
  no_dest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (f_d == '0) |=> $stable(reg_q));

  // R5
  one_load_chk: assert property (@(posedge clk) disable iff (rst)
    (f_d != '0) |-> $countones(ld_en) == 1);

  // R5
  load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_en));

  // R3
  ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (f_a == '0) && (f_op == OP_PASS) |=> data_out == $past(ext_in));

  // R6
  ext_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (f_a == '0) && (f_op == OP_INC) |=> data_out == $past(ext_in) + DATA_W'(1));

  // R7
  ext_xor_self_chk: assert property (@(posedge clk) disable iff (rst)
    (f_a == '0) && (f_b == '0) && (f_op == OP_XOR) |=> data_out == '0);

  // R10
  write_matches_out_chk: assert property (@(posedge clk) disable iff (rst)
    (f_d == SEL_W'(1)) |=> reg_q[0] == data_out);
endmodule

bind cw_datapath cw_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
  .data_out(data_out), .ld_en(ld_en), .reg_q(reg_q));

// File: tb/cw_datapath_bench.sv
module cw_datapath_bench;
  localparam int W = 16;
  localparam logic [4:0] PASS = 5'b00000, INC = 5'b00001, ADD = 5'b00010,
    SUB = 5'b00101, DEC = 5'b00110, AND_ = 5'b01000, OR_ = 5'b01010,
    XOR_ = 5'b01100, NOT_ = 5'b01110, SHR = 5'b10000, SHL = 5'b11000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [13:0]   ctrl_word = '0;
  logic [W-1:0]  ext_in = '0;
  logic [W-1:0]  data_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_reg [1:7];

  always #5 clk = ~clk;

  cw_datapath #(.DATA_W(W)) u_cw_datapath (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
    .data_out(data_out));

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] src(input logic [2:0] s, input logic [W-1:0] x);
    return (s == 3'd0) ? x : m_reg[s];
  endfunction

  function automatic logic [W-1:0] model(input logic [4:0] op,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      INC:  return a + 1'b1;
      ADD:  return a + b;
      SUB:  return a - b;
      DEC:  return a - 1'b1;
      AND_: return a & b;
      OR_:  return a | b;
      XOR_: return a ^ b;
      NOT_: return ~a;
      SHR:  return a >> 1;
      SHL:  return a << 1;
      default: return a;
    endcase
  endfunction

  // apply one control word, check data_out one cycle later, update model
  task automatic step(input string tag, input logic [2:0] a, input logic [2:0] b,
                      input logic [2:0] d, input logic [4:0] op, input logic [W-1:0] x);
    logic [W-1:0] exp;
    @(negedge clk);
    ctrl_word = {a, b, d, op};
    ext_in    = x;
    exp = model(op, src(a, x), src(b, x));
    @(posedge clk);
    @(negedge clk);
    check(tag, data_out, exp);
    if (d != 3'd0) m_reg[d] = exp;
  endtask

  task automatic readback(input string tag);
    for (int r = 1; r <= 7; r++)
      step(tag, 3'(r), 3'd0, 3'd0, PASS, 16'hDEAD);
  endtask

  task automatic t_reset;
    for (int r = 1; r <= 7; r++) m_reg[r] = '0;
    check("R1 out", data_out, '0);
    readback("R1 regs");
  endtask

  task automatic t_load;
    for (int r = 1; r <= 7; r++)
      step("R3 R5 load", 3'd0, 3'd0, 3'(r), PASS, 16'h1100 + 16'(r));
    readback("R2 R5 select");
  endtask

  task automatic t_no_write;
    step("R4 op", 3'd2, 3'd3, 3'd0, ADD, 16'h0);
    step("R4 ext", 3'd0, 3'd0, 3'd0, NOT_, 16'h5A5A);
    readback("R4 hold");
  endtask

  task automatic t_arith;
    step("R6 add", 3'd2, 3'd3, 3'd1, ADD, 16'h0);
    step("R6 sub", 3'd1, 3'd7, 3'd4, SUB, 16'h0);
    step("R6 inc wrap", 3'd0, 3'd0, 3'd5, INC, 16'hFFFF);
    step("R6 dec wrap", 3'd5, 3'd0, 3'd6, DEC, 16'h0);
    step("R6 sub ext", 3'd0, 3'd2, 3'd0, SUB, 16'h0001);
    readback("R6 regs");
  endtask

  task automatic t_logic;
    step("R7 and", 3'd0, 3'd2, 3'd7, AND_, 16'hF0F0);
    step("R7 or", 3'd0, 3'd3, 3'd0, OR_, 16'h0F00);
    step("R7 xor", 3'd4, 3'd0, 3'd0, XOR_, 16'hAAAA);
    step("R7 not", 3'd7, 3'd0, 3'd2, NOT_, 16'h0);
    step("R7 pass", 3'd2, 3'd0, 3'd0, PASS, 16'h0);
  endtask

  task automatic t_shift;
    step("R8 shr", 3'd0, 3'd0, 3'd0, SHR, 16'h8001);
    step("R8 shl", 3'd0, 3'd0, 3'd0, SHL, 16'h8001);
    step("R8 shl reg", 3'd0, 3'd0, 3'd3, SHL, 16'hC003);
    step("R8 shr reg", 3'd3, 3'd0, 3'd3, SHR, 16'h0);
  endtask

  task automatic t_unlisted;
    step("R9 code03", 3'd0, 3'd1, 3'd0, 5'b00011, 16'h1234);
    step("R9 code04", 3'd0, 3'd1, 3'd0, 5'b00100, 16'h4321);
    step("R9 code11", 3'd0, 3'd1, 3'd0, 5'b10001, 16'h0F0F);
    step("R9 code1F", 3'd0, 3'd1, 3'd6, 5'b11111, 16'hBEEF);
  endtask

  task automatic t_self;
    step("R11 seed", 3'd0, 3'd0, 3'd3, PASS, 16'h0123);
    step("R11 g3+g3", 3'd3, 3'd3, 3'd3, ADD, 16'h0);
    step("R11 g3-g3", 3'd3, 3'd3, 3'd3, SUB, 16'h0);
    readback("R11 regs");
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst = 1'b1;
    ctrl_word = {3'd0, 3'd0, 3'd1, PASS};
    ext_in = 16'h7777;
    @(negedge clk);
    rst = 1'b0;
    ctrl_word = '0;
    for (int r = 1; r <= 7; r++) m_reg[r] = '0;
    check("R1 mid out", data_out, '0);
    readback("R1 mid regs");
  endtask

  // R10: output follows every word, back to back, with no destination
  task automatic t_stream;
    step("R10 a", 3'd0, 3'd0, 3'd0, INC, 16'h0010);
    step("R10 b", 3'd0, 3'd0, 3'd0, DEC, 16'h0010);
    step("R10 c", 3'd0, 3'd0, 3'd0, ADD, 16'h8000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_no_write();
    t_arith();
    t_logic();
    t_shift();
    t_unlisted();
    t_self();
    t_stream();
    t_mid_reset();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule